// File: doc/BRIEF.md
# Fetch-Stage Branch Target Buffer

This block sits beside the fetch program counter. In every cycle it uses the current fetch address to pick one slot of a direct-mapped table. If that slot is valid and its stored address tag equals the upper bits of the fetch address, the block reports a hit. When the slot's two-bit confidence counter leans toward taken, the stored target is driven as the next fetch address in the same cycle. In every other case the next fetch address is the sequential one, PC+4. Because the full tag is compared, a branch whose index collides with another branch cannot borrow that branch's target.

A separate training port reports each branch once it has resolved. If the branch's slot already holds it, the counter moves one step toward the outcome and, on a taken outcome, the stored target is refreshed. If the branch is absent and was taken, it takes over its slot and replaces whatever was stored there. An absent branch that was not taken leaves the table untouched. The lookup path is purely combinational. A training write becomes visible only after the next rising clock edge.

Top module: `btb_top`

## Requirements
- R1: While reset is asserted, and straight after it, every slot is invalid, so `hit_o` is 0 and `next_pc_o` equals `fetch_pc_i + 4`.
- R2: A hit requires a valid slot whose stored tag (address bits 31..6 with 16 slots) equals that of `fetch_pc_i`. An address that shares the slot index (bits 5..2) but differs in any tag bit misses and yields `fetch_pc_i + 4`.
- R3: On a hit whose counter is 2 or 3, `pred_taken_o` is 1 and `next_pc_o` is the stored target.
- R4: On a hit whose counter is 0 or 1, `pred_taken_o` is 0 and `next_pc_o` is `fetch_pc_i + 4`. On a miss, `pred_taken_o` is also 0.
- R5: A resolved taken branch that misses writes its tag and target into its slot with counter 2 (weakly taken), replacing the previous occupant. That occupant then misses.
- R6: A resolved not-taken branch that misses changes no slot.
- R7: A resolved branch that hits moves its counter up by one when taken and down by one when not taken, and holds the counter at 3 and at 0.
- R8: A taken update on a hit replaces the stored target. A not-taken update on a hit keeps the stored target.
- R9: A training write in one cycle is not visible to a lookup in that same cycle. It is visible from the next cycle on.
- R10: The sequential address wraps modulo 2^32, so fetch address 0xFFFFFFFC yields 0x00000000 on a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset; clears all valid bits |
| fetch_pc_i | input | 32 | Current fetch address |
| hit_o | output | 1 | Fetch address matches a valid stored branch |
| pred_taken_o | output | 1 | Hit with a taken-leaning counter |
| next_pc_o | output | 32 | Predicted next fetch address |
| upd_valid_i | input | 1 | A resolved branch is reported this cycle |
| upd_pc_i | input | 32 | Address of the resolved branch |
| upd_taken_i | input | 1 | Resolved outcome, 1 for taken |
| upd_target_i | input | 32 | Resolved target address |

## Verification
Lookups are tried on three kinds of address: never-trained addresses, trained addresses, and aliases that share a trained slot index but differ in the tag. The aliases include one that differs only in the top bit. Together these separate a genuine tag match from an index-only match. Long runs of same-direction training show whether the counter saturates correctly and whether prediction flips at the 1/2 boundary. Training a branch while fetching that same address in the same cycle shows whether the write is visible too early. Eviction by a colliding branch and a random mix of fetches and updates over a small address pool test replacement and not-taken filtering against the reference model.

// File: rtl/btb_pkg.sv
package btb_pkg;

  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_TRAIN = 2'd1,
    ACT_ALLOC = 2'd2
  } upd_act_e;

  // Only taken misses claim a slot; not-taken misses are dropped.
  function automatic upd_act_e pick_act(input logic req, input logic match, input logic taken);
    if (!req)  return ACT_NONE;
    if (match) return ACT_TRAIN;
    if (taken) return ACT_ALLOC;
    return ACT_NONE;
  endfunction

endpackage

// File: rtl/btb_sat_ctr.sv
module btb_sat_ctr #(
  parameter int W = 2
) (
  input  logic [W-1:0] cnt_i,
  input  logic         taken_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  always_comb begin
    cnt_o = cnt_i;
    if (taken_i && (cnt_i != CNT_MAX))     cnt_o = cnt_i + W'(1);
    else if (!taken_i && (cnt_i != '0))    cnt_o = cnt_i - W'(1);
  end
endmodule

// File: rtl/btb_array.sv
module btb_array #(
  parameter int ENTRIES = 16,
  parameter int TAG_W   = 26,
  parameter int ADDR_W  = 32,
  parameter int CNT_W   = 2,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [TAG_W-1:0]  wtag_i,
  input  logic [ADDR_W-1:0] wtgt_i,
  input  logic [CNT_W-1:0]  wcnt_i,
  input  logic [IDX_W-1:0]  a_idx_i,
  output logic              a_valid_o,
  output logic [TAG_W-1:0]  a_tag_o,
  output logic [ADDR_W-1:0] a_tgt_o,
  output logic [CNT_W-1:0]  a_cnt_o,
  input  logic [IDX_W-1:0]  b_idx_i,
  output logic              b_valid_o,
  output logic [TAG_W-1:0]  b_tag_o,
  output logic [ADDR_W-1:0] b_tgt_o,
  output logic [CNT_W-1:0]  b_cnt_o
);
  logic              valid_q [ENTRIES];
  logic [TAG_W-1:0]  tag_q   [ENTRIES];
  logic [ADDR_W-1:0] tgt_q   [ENTRIES];
  logic [CNT_W-1:0]  cnt_q   [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic sel;
    assign sel = we_i && (widx_i == IDX_W'(e));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[e] <= 1'b0;
        tag_q[e]   <= '0;
        tgt_q[e]   <= '0;
        cnt_q[e]   <= '0;
      end else if (sel) begin
        valid_q[e] <= 1'b1;
        tag_q[e]   <= wtag_i;
        tgt_q[e]   <= wtgt_i;
        cnt_q[e]   <= wcnt_i;
      end
    end
  end

  assign a_valid_o = valid_q[a_idx_i];
  assign a_tag_o   = tag_q[a_idx_i];
  assign a_tgt_o   = tgt_q[a_idx_i];
  assign a_cnt_o   = cnt_q[a_idx_i];

  assign b_valid_o = valid_q[b_idx_i];
  assign b_tag_o   = tag_q[b_idx_i];
  assign b_tgt_o   = tgt_q[b_idx_i];
  assign b_cnt_o   = cnt_q[b_idx_i];
endmodule

// File: rtl/btb_lookup.sv
module btb_lookup #(
  parameter int ADDR_W      = 32,
  parameter int TAG_W       = 26,
  parameter int INSTR_BYTES = 4
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [TAG_W-1:0]  pc_tag_i,
  input  logic              ent_valid_i,
  input  logic [TAG_W-1:0]  ent_tag_i,
  input  logic [ADDR_W-1:0] ent_tgt_i,
  input  logic              ent_dir_i,
  output logic              hit_o,
  output logic              taken_o,
  output logic [ADDR_W-1:0] next_pc_o
);
  logic [ADDR_W-1:0] seq_pc;

  assign seq_pc    = pc_i + ADDR_W'(INSTR_BYTES);
  assign hit_o     = ent_valid_i && (ent_tag_i == pc_tag_i);
  assign taken_o   = hit_o && ent_dir_i;
  assign next_pc_o = taken_o ? ent_tgt_i : seq_pc;
endmodule

// File: rtl/btb_top.sv
module btb_top
  import btb_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int ENTRIES     = 16,
  parameter int CNT_W       = 2,
  parameter int INSTR_BYTES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] fetch_pc_i,
  output logic              hit_o,
  output logic              pred_taken_o,
  output logic [ADDR_W-1:0] next_pc_o,
  input  logic              upd_valid_i,
  input  logic [ADDR_W-1:0] upd_pc_i,
  input  logic              upd_taken_i,
  input  logic [ADDR_W-1:0] upd_target_i
);
  localparam int OFS_W = $clog2(INSTR_BYTES);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = ADDR_W - IDX_W - OFS_W;
  localparam logic [CNT_W-1:0] CNT_INIT = {1'b1, {(CNT_W-1){1'b0}}};

  logic [IDX_W-1:0]  f_idx, u_idx;
  logic [TAG_W-1:0]  f_tag, u_tag;
  logic              f_valid, u_valid;
  logic [TAG_W-1:0]  f_tag_rd, u_tag_rd;
  logic [ADDR_W-1:0] f_tgt_rd, u_tgt_rd;
  logic [CNT_W-1:0]  f_cnt_rd, u_cnt_rd, u_cnt_nxt;
  logic              u_match, we;
  logic [ADDR_W-1:0] w_tgt;
  logic [CNT_W-1:0]  w_cnt;
  upd_act_e          act;
  logic              unused_lo;

  assign f_idx = fetch_pc_i[OFS_W +: IDX_W];
  assign f_tag = fetch_pc_i[ADDR_W-1 -: TAG_W];
  assign u_idx = upd_pc_i[OFS_W +: IDX_W];
  assign u_tag = upd_pc_i[ADDR_W-1 -: TAG_W];
  assign unused_lo = ^{fetch_pc_i[OFS_W-1:0], upd_pc_i[OFS_W-1:0], f_cnt_rd[CNT_W-2:0]};

  btb_array #(
    .ENTRIES(ENTRIES), .TAG_W(TAG_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
  ) u_array (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (we),
    .widx_i   (u_idx),
    .wtag_i   (u_tag),
    .wtgt_i   (w_tgt),
    .wcnt_i   (w_cnt),
    .a_idx_i  (f_idx),
    .a_valid_o(f_valid),
    .a_tag_o  (f_tag_rd),
    .a_tgt_o  (f_tgt_rd),
    .a_cnt_o  (f_cnt_rd),
    .b_idx_i  (u_idx),
    .b_valid_o(u_valid),
    .b_tag_o  (u_tag_rd),
    .b_tgt_o  (u_tgt_rd),
    .b_cnt_o  (u_cnt_rd)
  );

  btb_lookup #(
    .ADDR_W(ADDR_W), .TAG_W(TAG_W), .INSTR_BYTES(INSTR_BYTES)
  ) u_lookup (
    .pc_i       (fetch_pc_i),
    .pc_tag_i   (f_tag),
    .ent_valid_i(f_valid),
    .ent_tag_i  (f_tag_rd),
    .ent_tgt_i  (f_tgt_rd),
    .ent_dir_i  (f_cnt_rd[CNT_W-1]),
    .hit_o      (hit_o),
    .taken_o    (pred_taken_o),
    .next_pc_o  (next_pc_o)
  );

  btb_sat_ctr #(.W(CNT_W)) u_ctr (
    .cnt_i  (u_cnt_rd),
    .taken_i(upd_taken_i),
    .cnt_o  (u_cnt_nxt)
  );

  assign u_match = u_valid && (u_tag_rd == u_tag);
  assign act     = pick_act(upd_valid_i, u_match, upd_taken_i);

  always_comb begin
    we    = (act != ACT_NONE);
    w_cnt = (act == ACT_ALLOC) ? CNT_INIT : u_cnt_nxt;
    w_tgt = upd_taken_i ? upd_target_i : u_tgt_rd;
  end
endmodule

// File: rtl/btb_chk.sv
module btb_chk #(
  parameter int ADDR_W      = 32,
  parameter int INSTR_BYTES = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] fetch_pc_i,
  input logic              hit_o,
  input logic              pred_taken_o,
  input logic [ADDR_W-1:0] next_pc_o,
  input logic              upd_valid_i,
  input logic [ADDR_W-1:0] upd_pc_i,
  input logic              upd_taken_i,
  input logic [ADDR_W-1:0] upd_target_i
);
  logic [ADDR_W-1:0] seq_pc;
  assign seq_pc = fetch_pc_i + ADDR_W'(INSTR_BYTES);

  assert_reset_idle_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (!hit_o && next_pc_o == seq_pc));

  assert_miss_seq_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (next_pc_o == seq_pc && !pred_taken_o));

  assert_taken_hit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_taken_o |-> hit_o);

  assert_nt_seq_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && !pred_taken_o) |-> next_pc_o == seq_pc);

  assert_alloc_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(upd_valid_i && upd_taken_i) && fetch_pc_i == $past(upd_pc_i)) |-> hit_o);

  assert_refresh_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(upd_valid_i && upd_taken_i) && fetch_pc_i == $past(upd_pc_i) && pred_taken_o)
      |-> next_pc_o == $past(upd_target_i));
endmodule

bind btb_top btb_chk #(.ADDR_W(ADDR_W), .INSTR_BYTES(INSTR_BYTES)) u_chk (.*);

// File: tb/tb_btb_top.sv
module tb_btb_top;
  localparam int NE = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] fetch_pc;
  logic        hit, ptaken;
  logic [31:0] next_pc;
  logic        upd_v, upd_t;
  logic [31:0] upd_pc, upd_tg;

  always #5 clk = ~clk;

  btb_top dut (
    .clk_i(clk), .rst_ni(rst_n), .fetch_pc_i(fetch_pc),
    .hit_o(hit), .pred_taken_o(ptaken), .next_pc_o(next_pc),
    .upd_valid_i(upd_v), .upd_pc_i(upd_pc), .upd_taken_i(upd_t), .upd_target_i(upd_tg)
  );

  int checks = 0;
  int errors = 0;

  // reference model: per-slot record keyed by slot number
  bit        m_v   [NE];
  bit [31:0] m_pc  [NE];
  bit [31:0] m_tgt [NE];
  int        m_cnt [NE];

  function automatic int slot(bit [31:0] pc);
    return int'((pc >> 2) % NE);
  endfunction

  function automatic bit m_hit(bit [31:0] pc);
    return m_v[slot(pc)] && ((m_pc[slot(pc)] >> 6) == (pc >> 6));
  endfunction

  task automatic model_clear();
    for (int i = 0; i < NE; i++) begin
      m_v[i] = 0; m_pc[i] = 0; m_tgt[i] = 0; m_cnt[i] = 0;
    end
  endtask

  task automatic model_update();
    int s;
    if (!upd_v) return;
    s = slot(upd_pc);
    if (m_hit(upd_pc)) begin
      if (upd_t) begin
        if (m_cnt[s] < 3) m_cnt[s]++;
        m_tgt[s] = upd_tg;
      end else if (m_cnt[s] > 0) m_cnt[s]--;
    end else if (upd_t) begin
      m_v[s] = 1; m_pc[s] = upd_pc; m_tgt[s] = upd_tg; m_cnt[s] = 2;
    end
  endtask

  task automatic expect_out(string req);
    bit        e_hit, e_tk;
    bit [31:0] e_nx;
    e_hit = m_hit(fetch_pc);
    e_tk  = e_hit && (m_cnt[slot(fetch_pc)] >= 2);
    e_nx  = e_tk ? m_tgt[slot(fetch_pc)] : fetch_pc + 32'd4;
    checks++;
    if (hit !== e_hit || ptaken !== e_tk || next_pc !== e_nx) begin
      errors++;
      $display("FAIL %s pc=%h: hit=%b taken=%b next=%h expected hit=%b taken=%b next=%h",
               req, fetch_pc, hit, ptaken, next_pc, e_hit, e_tk, e_nx);
    end
  endtask

  task automatic step(input bit [31:0] fpc, input bit uv, input bit [31:0] upc,
                      input bit ut, input bit [31:0] utg, input string req);
    @(negedge clk);
    fetch_pc = fpc; upd_v = uv; upd_pc = upc; upd_t = ut; upd_tg = utg;
    #1;
    expect_out(req);
    @(posedge clk);
    model_update();
  endtask

  task automatic look(input bit [31:0] fpc, input string req);
    step(fpc, 1'b0, 32'h0, 1'b0, 32'h0, req);
  endtask

  task automatic train(input bit [31:0] pc, input bit t, input bit [31:0] tg, input string req);
    step(pc, 1'b1, pc, t, tg, req);
  endtask

  localparam bit [31:0] PA = 32'h0000_1000;
  localparam bit [31:0] PB = 32'h0000_1040; // same slot as PA, other tag
  localparam bit [31:0] PC = 32'h0000_2008;

  initial begin
    rst_n = 1'b1; fetch_pc = 32'h100; upd_v = 0; upd_pc = 0; upd_t = 0; upd_tg = 0;
    model_clear();
    #2 rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk); fetch_pc = 32'h100; #1; expect_out("R1");
    @(negedge clk); rst_n = 1'b1;
    look(32'h100, "R1");
    look(PA, "R1");

    // R6: not-taken miss allocates nothing
    train(PA, 1'b0, 32'h5000, "R6");
    look(PA, "R6");
    // R9 then R5/R3: taken miss allocates, visible next cycle only
    train(PA, 1'b1, 32'h5000, "R9");
    look(PA, "R5");
    look(PA, "R3");
    // R2: index aliases must miss
    look(PB, "R2");
    look(PA ^ 32'h8000_0000, "R2");
    look(PA + 32'd4, "R2");

    // R7 / R4 counter walk: 2->1->0->0, then up to 3 and back to 2
    train(PA, 1'b0, 32'h0, "R7");
    train(PA, 1'b0, 32'h0, "R4");
    train(PA, 1'b0, 32'h0, "R7");
    look(PA, "R4");
    train(PA, 1'b1, 32'h5000, "R7");
    look(PA, "R7");
    train(PA, 1'b1, 32'h5000, "R7");
    train(PA, 1'b1, 32'h5000, "R7");
    train(PA, 1'b1, 32'h5000, "R7");
    train(PA, 1'b0, 32'h0, "R7");
    look(PA, "R7");

    // R8: taken refreshes target, not-taken keeps it
    train(PA, 1'b1, 32'h6000, "R8");
    look(PA, "R8");
    train(PA, 1'b0, 32'h7000, "R8");
    look(PA, "R8");

    // R5: colliding taken branch evicts occupant
    step(PC, 1'b1, PB, 1'b1, 32'h9000, "R5");
    look(PB, "R5");
    look(PA, "R5");
    look(PC, "R2");

    // R10: sequential wrap
    look(32'hFFFF_FFFC, "R10");
    train(32'hFFFF_FFFC, 1'b1, 32'h40, "R10");
    look(32'hFFFF_FFFC, "R10");

    // mixed traffic over a small pool with aliases
    for (int i = 0; i < 400; i++) begin
      bit [31:0] fp, up;
      fp = 32'h1000 + ($urandom % 8) * 4 + ($urandom % 3) * 64;
      up = 32'h1000 + ($urandom % 8) * 4 + ($urandom % 3) * 64;
      step(fp, ($urandom % 2) == 0, up, ($urandom % 3) != 0,
           32'h8000 + ($urandom % 256) * 4, "R7");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run still active, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule